// File: doc/BRIEF.md
# Hardware Counting Semaphore

This block keeps one shared counting semaphore for a group of requesters. Each requester raises a request with an operation bit that selects acquire or release. An acquire that finds a free unit takes it at once. An acquire that finds the count at zero parks the requester in a waiting flag. A later release then hands its unit straight to one parked requester and leaves the count unchanged. When nobody is parked, a release adds one to the count.

Exactly one operation is accepted per clock, which makes every acquire and release atomic with respect to all other requesters. Competing new requests are served in round-robin order. A second round-robin picker of the same design chooses which parked requester to wake. Completion is signalled by a one-cycle grant pulse, and a requester holds its request until that pulse arrives. A load port sets the count, and so sets how many holders may own the semaphore at once. The load port is honoured only while no requester is parked.

Top module: `counting_sem`

## Requirements
- R1: After reset the count equals the INIT_COUNT parameter, no waiting flag is set and no grant is asserted.
- R2: An accepted acquire with a non-zero count lowers the count by one and pulses that requester's grant in the following cycle.
- R3: An accepted acquire with a zero count sets that requester's waiting flag, gives no grant, and leaves the count at zero; the count never wraps below zero.
- R4: An accepted release with no requester waiting raises the count by one, saturating at 2**CNT_W-1, and pulses the releaser's grant in the following cycle.
- R5: An accepted release while requesters wait clears exactly one waiting flag, pulses the grants of both the woken requester and the releaser, and leaves the count unchanged.
- R6: At most one new operation is accepted per cycle. Among requesters that are neither waiting nor granted, the winner is the first found searching upward (with wrap) from the index after the previous winner, starting at index 0 after reset.
- R7: The woken requester is the first waiting one found searching upward (with wrap) from the index after the previously woken one, starting at index 0 after reset.
- R8: Every grant is a single-cycle pulse; a requester whose grant is high, or which is waiting, is not accepted again in that cycle.
- R9: A load request while no requester waits sets the count to the load value in the next cycle, and no operation is accepted in that cycle.
- R10: A load request while any requester waits is ignored; the count is not changed by it.
- R11: The operation bit req_op of a requester encodes 0 as acquire and 1 as release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_REQ | Per-requester request, held until grant |
| req_op | input | N_REQ | Per-requester operation: 0 acquire, 1 release |
| init_valid | input | 1 | Request to load the count |
| init_value | input | CNT_W | Value to load |
| grant | output | N_REQ | One-cycle completion pulse per requester |
| waiting | output | N_REQ | Per-requester parked flag |
| count | output | CNT_W | Current free units |

## Verification
Every result of an accepted operation (count change, waiting flag change, grant pulse) is registered, so it is due exactly one clock after the edge that accepted it. A load is likewise due one clock after the edge at which it is presented. The bench drives inputs on the falling edge and predicts, with a behavioural model stepped from those same inputs, the state after the next rising edge. It compares the count, the waiting flags and the grants on the following falling edge. Directed checks after each scenario pin down literal counts and flags for parking, hand-off, saturation, loading and ignored loads.

// File: rtl/sem_pkg.sv
package sem_pkg;
   // operation encoding carried on req_op
   typedef enum logic {
      SEM_ACQUIRE = 1'b0,
      SEM_RELEASE = 1'b1
   } sem_op_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/sem_rr_arbiter.sv
module sem_rr_arbiter #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         advance,
   output logic [N-1:0] gnt
);
   localparam int unsigned PW = sem_pkg::idx_width(N);
   localparam logic [PW-1:0] LAST = PW'(N - 1);

   logic [PW-1:0] ptr_q;
   logic [PW-1:0] sel;

   always_comb begin
      int unsigned slot;
      logic found;
      gnt   = '0;
      sel   = '0;
      found = 1'b0;
      for (int unsigned k = 0; k < N; k++) begin
         slot = (int'(ptr_q) + k) % N;
         if (!found && req[slot]) begin
            gnt[slot] = 1'b1;
            sel       = PW'(slot);
            found     = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (advance && (|req))
         ptr_q <= (sel == LAST) ? '0 : sel + 1'b1;
   end

   assert_pick_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt) && ((gnt & ~req) == '0));

   assert_pick_when_any_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> (|gnt));
endmodule

// File: rtl/sem_count_unit.sv
module sem_count_unit #(
   parameter int unsigned CNT_W      = 4,
   parameter int unsigned INIT_COUNT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_value,
   input  logic             dec,
   input  logic             inc,
   output logic [CNT_W-1:0] count,
   output logic             is_zero
);
   localparam logic [CNT_W-1:0] CMAX  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CINIT = CNT_W'(INIT_COUNT);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= CINIT;
      else if (load)
         cnt_q <= load_value;
      else if (dec && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
      else if (inc && (cnt_q != CMAX))
         cnt_q <= cnt_q + 1'b1;
   end

   assign count   = cnt_q;
   assign is_zero = (cnt_q == '0);

   assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_zero && !load) |=> (count <= CNT_W'(1)));

   assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CMAX && !load) |=> (count >= CMAX - 1'b1));
endmodule

// File: rtl/counting_sem.sv
module counting_sem #(
   parameter int unsigned N_REQ      = 4,
   parameter int unsigned CNT_W      = 4,
   parameter int unsigned INIT_COUNT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] req_valid,
   input  logic [N_REQ-1:0] req_op,
   input  logic             init_valid,
   input  logic [CNT_W-1:0] init_value,
   output logic [N_REQ-1:0] grant,
   output logic [N_REQ-1:0] waiting,
   output logic [CNT_W-1:0] count
);
   localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

   generate
      if (N_REQ < 2) begin : g_bad_nreq
         $error("counting_sem: N_REQ must be at least 2");
      end
      if (CNT_W < 1 || CNT_W > 30) begin : g_bad_cntw
         $error("counting_sem: CNT_W out of range");
      end
      if (INIT_COUNT > CNT_MAX) begin : g_bad_init
         $error("counting_sem: INIT_COUNT exceeds counter range");
      end
   endgenerate

   logic [N_REQ-1:0] grant_q, wait_q;
   logic [N_REQ-1:0] eligible, sel_new, sel_wake;
   logic             load_take, have_new, is_rel, any_wait, cnt_zero;
   logic             acq_ok, acq_park, rel_hand, rel_inc;

   assign any_wait  = |wait_q;
   assign load_take = init_valid && !any_wait;
   assign eligible  = req_valid & ~wait_q & ~grant_q;
   assign have_new  = (|eligible) && !load_take;
   assign is_rel    = (|(req_op & sel_new)) == sem_pkg::SEM_RELEASE;

   assign acq_ok    = have_new && !is_rel && !cnt_zero;
   assign acq_park  = have_new && !is_rel &&  cnt_zero;
   assign rel_hand  = have_new &&  is_rel &&  any_wait;
   assign rel_inc   = have_new &&  is_rel && !any_wait;

   sem_rr_arbiter #(.N(N_REQ)) u_new_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (eligible),
      .advance (have_new),
      .gnt     (sel_new)
   );

   sem_rr_arbiter #(.N(N_REQ)) u_wake_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (wait_q),
      .advance (rel_hand),
      .gnt     (sel_wake)
   );

   sem_count_unit #(.CNT_W(CNT_W), .INIT_COUNT(INIT_COUNT)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load_take),
      .load_value (init_value),
      .dec        (acq_ok),
      .inc        (rel_inc),
      .count      (count),
      .is_zero    (cnt_zero)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_q <= '0;
         wait_q  <= '0;
      end else begin
         grant_q <= ((acq_ok || (have_new && is_rel)) ? sel_new : '0)
                  | (rel_hand ? sel_wake : '0);
         wait_q  <= (wait_q | (acq_park ? sel_new : '0))
                  & ~(rel_hand ? sel_wake : '0);
      end
   end

   assign grant   = grant_q;
   assign waiting = wait_q;

   assert_park_only_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(waiting & ~$past(waiting))) |-> ($past(count) == '0));

   assert_handoff_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(waiting) & ~waiting)) |-> (count == $past(count)));

   assert_wake_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones($past(waiting) & ~waiting) <= 1);

   assert_grant_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & $past(grant)) == '0);

   assert_grant_not_waiting_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & waiting) == '0);
endmodule

// File: tb/counting_sem_test.sv
module counting_sem_test;
   localparam int N        = 4;
   localparam int W        = 4;
   localparam int INIT     = 2;
   localparam int MAXC     = (1 << W) - 1;
   localparam time CLK_PER = 10ns;
   localparam int QD       = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req_valid = '0;
   logic [N-1:0] req_op = '0;
   logic         init_valid = 1'b0;
   logic [W-1:0] init_value = '0;
   logic [N-1:0] grant, waiting;
   logic [W-1:0] count;

   counting_sem #(.N_REQ(N), .CNT_W(W), .INIT_COUNT(INIT)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .init_valid(init_valid), .init_value(init_value),
      .grant(grant), .waiting(waiting), .count(count)
   );

   always #(CLK_PER/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit done   = 0;

   // reference state
   logic [N-1:0] m_grant = '0, m_wait = '0, prev_grant = '0;
   int m_count = INIT;
   int rptr = 0, wptr = 0;
   bit opq [N][QD];
   int qh [N];
   int qt [N];
   bit init_pend = 0;
   int init_pend_val = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int pick(input logic [N-1:0] v, input int p);
      for (int k = 0; k < N; k++) begin
         int s = (p + k) % N;
         if (v[s]) return s;
      end
      return -1;
   endfunction

   task automatic model_step();
      logic [N-1:0] nw = m_wait;
      logic [N-1:0] ng = '0;
      int nc = m_count;
      if (init_valid && m_wait == '0) begin
         nc = int'(init_value);
      end else begin
         logic [N-1:0] el = req_valid & ~m_wait & ~m_grant;
         int w = pick(el, rptr);
         if (w >= 0) begin
            rptr = (w + 1) % N;
            if (req_op[w] == 1'b0) begin          // R11: 0 is acquire
               if (m_count > 0) begin nc = m_count - 1; ng[w] = 1'b1; end
               else nw[w] = 1'b1;
            end else if (m_wait != '0) begin      // R11: 1 is release
               int v = pick(m_wait, wptr);
               wptr = (v + 1) % N;
               nw[v] = 1'b0;
               ng[v] = 1'b1;
               ng[w] = 1'b1;
            end else begin
               if (nc < MAXC) nc = nc + 1;
               ng[w] = 1'b1;
            end
         end
      end
      m_wait = nw; m_grant = ng; m_count = nc;
   endtask

   task automatic tick();
      @(negedge clk);
      cyc++;
      chk(int'(count) == m_count, "R3 count", int'(count), m_count);
      chk(waiting == m_wait, "R7 waiting", int'(waiting), int'(m_wait));
      chk(grant == m_grant, "R6 grant", int'(grant), int'(m_grant));
      chk((grant & prev_grant) == '0, "R8 grant pulse", int'(grant & prev_grant), 0);
      prev_grant = grant;
      for (int i = 0; i < N; i++) if (m_grant[i]) qh[i]++;
      for (int i = 0; i < N; i++) begin
         req_valid[i] = (qh[i] < qt[i]);
         req_op[i]    = (qh[i] < qt[i]) ? opq[i][qh[i] % QD] : 1'b0;
      end
      init_valid = init_pend;
      init_value = W'(init_pend_val);
      init_pend  = 0;
      model_step();
   endtask

   task automatic run(input int n);
      for (int k = 0; k < n; k++) tick();
   endtask

   task automatic push(input int i, input bit op);
      opq[i][qt[i] % QD] = op;
      qt[i]++;
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin qh[i] = 0; qt[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(int'(count) == INIT, "R1 reset count", int'(count), INIT);
      chk(waiting == '0, "R1 reset waiting", int'(waiting), 0);
      chk(grant == '0, "R1 reset grant", int'(grant), 0);

      // three acquires at once, two units: R2, R6, R11, third parks (R3)
      push(0, 1'b0); push(1, 1'b0); push(2, 1'b0);
      run(8);
      chk(int'(count) == 0, "R2 count after two acquires", int'(count), 0);
      chk(waiting == 4'b0100, "R3 third acquire parks", int'(waiting), 4);

      // another parks; load attempted while waiting is ignored (R10)
      push(3, 1'b0);
      run(4);
      init_pend = 1; init_pend_val = 9;
      run(3);
      chk(int'(count) == 0, "R10 load ignored while waiting", int'(count), 0);
      chk(waiting == 4'b1100, "R3 two parked", int'(waiting), 12);

      // release hands off to waiter 2 first, then 3 (R5, R7)
      push(0, 1'b1);
      run(4);
      chk(waiting == 4'b1000, "R7 first woken is index 2", int'(waiting), 8);
      chk(int'(count) == 0, "R5 hand-off keeps count", int'(count), 0);
      push(1, 1'b1);
      run(4);
      chk(waiting == 4'b0000, "R5 second hand-off", int'(waiting), 0);

      // releases with nobody waiting raise the count (R4)
      push(2, 1'b1); push(3, 1'b1);
      run(6);
      chk(int'(count) == 2, "R4 count after releases", int'(count), 2);

      // load with no waiter (R9), then saturating releases (R4)
      init_pend = 1; init_pend_val = 14;
      push(0, 1'b1);
      run(3);
      push(0, 1'b1); push(0, 1'b1);
      run(10);
      chk(int'(count) == MAXC, "R4 saturation", int'(count), MAXC);
      push(1, 1'b0);
      run(3);
      chk(int'(count) == MAXC - 1, "R2 acquire after load", int'(count), MAXC - 1);

      // load to zero, then mixed contention
      init_pend = 1; init_pend_val = 0;
      run(2);
      chk(int'(count) == 0, "R9 load value applied", int'(count), 0);
      push(0, 1'b0); push(1, 1'b0); push(2, 1'b0); push(3, 1'b1);
      run(10);
      push(3, 1'b1); push(3, 1'b1); push(3, 1'b1);
      run(14);
      chk(waiting == '0, "R7 all waiters served", int'(waiting), 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule